// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block produces the bit timing of a CAN controller node. A programmable divider turns the system clock into time quanta. Each nominal bit is then built from four segments that always come in the same order: a one-quantum synchronization segment, a propagation segment, and two phase buffer segments. The propagation segment is placed ahead of the phase buffers and is sized for the round-trip delay between nodes. This lets a transmitting node still see a dominant bit that another node, synchronized to it, drives back onto the bus.

The unit emits a transmit-point strobe at the start of every bit and a sample strobe at the end of the first phase buffer. At the sample strobe it latches the received bus bit and compares it with the bit being transmitted. While the bus is idle, a falling edge on the received line, which is the recessive-to-dominant transition of a start of frame, restarts the bit at once. During a frame, such an edge stretches the first phase buffer or shortens the second, and never by more than the jump width. Frame decoding, stuffing, CRC and error counting belong to the controller around this block.

Top module: `can_bit_timing`

## Requirements
- R1: While reset is low, and right after it is released, `sample_bit` is 1 (recessive) and `sample_stb`, `tx_stb` and `bit_err` are 0.
- R2: One time quantum lasts `tq_div`+1 clock cycles, for every `tq_div` code from 0 to 63.
- R3: A bit is made of a synchronization segment of 1 quantum, a propagation segment of `prop_len`+1 quanta, phase buffer 1 of `ph1_len`+1 quanta and phase buffer 2, in that order. `tx_stb` is a one-cycle pulse at the start of each synchronization segment, so two consecutive pulses are one bit time apart when no synchronization occurs. `tx_stb` and `sample_stb` are never high together.
- R4: `sample_stb` is a one-cycle pulse at the end of phase buffer 1, (`tq_div`+1)·(1+P+P1) cycles after `tx_stb`, where P and P1 are the two lengths in quanta. In the same cycle, `sample_bit` shows `rx_bit` as it was at that clock edge.
- R5: Phase buffer 2 lasts `ph2_len`+1 quanta. Code 0 is taken as 2 quanta.
- R6: With `bus_idle` high, a falling edge on `rx_bit` raises `tx_stb` in the next cycle and restarts the bit, so the next `sample_stb` follows that pulse by (`tq_div`+1)·(1+P+P1) cycles.
- R7: With `bus_idle` low and `tx_bit` high, a falling edge seen during quantum q (counted from 0) of the propagation segment lengthens phase buffer 1 by min(q+1, `sjw_len`+1) quanta. An edge in quantum q of phase buffer 1 uses P+q+1 in place of q+1.
- R8: Under the same conditions, a falling edge during quantum j of phase buffer 2 shortens that segment by min(P2−1−j, `sjw_len`+1) quanta, where P2 is its programmed length in quanta.
- R9: A falling edge while `tx_bit` is 0 (the node itself drives dominant) leaves the timing unchanged.
- R10: At most one synchronization takes effect per bit. A later edge in the same bit changes nothing.
- R11: At each sample strobe, `bit_err` is set to 1 when the sampled bit differs from `tx_bit` and to 0 otherwise, and it holds that value until the next sample strobe. A dominant 0 on the bus is sampled as 0 even while `tx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_div | input | 6 | Quantum divider code; quantum = code+1 clocks |
| prop_len | input | 3 | Propagation segment length code (code+1 quanta) |
| ph1_len | input | 3 | Phase buffer 1 length code (code+1 quanta) |
| ph2_len | input | 3 | Phase buffer 2 length code (code+1 quanta, 0 means 2) |
| sjw_len | input | 2 | Jump width code (code+1 quanta) |
| rx_bit | input | 1 | Received bus level, 1 recessive, 0 dominant |
| tx_bit | input | 1 | Level the node is transmitting |
| bus_idle | input | 1 | High when no frame is in progress |
| sample_bit | output | 1 | Bus value latched at the last sample point |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| tx_stb | output | 1 | One-cycle pulse at the start of each bit |
| bit_err | output | 1 | Sampled bit differs from transmitted bit |

## Verification
Some properties are checked on every cycle: the strobes never coincide, each strobe is followed by the segment it announces, a stretch or shrink never exceeds the jump width, nothing changes once a bit has been synchronized, an edge caused by the node's own dominant bit never triggers a resynchronization, and the error flag always matches the latched sample. The exact cycle counts of the quantum divider, of each segment length and of each phase correction, and the way a hard synchronization restarts the bit, show up only as distances between strobes. The directed scenarios measure those distances against values computed from the requirements.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int SEG_W = 3;
  localparam int SJW_W = 2;
  localparam int Q_W   = SEG_W + 2;

  typedef logic [Q_W-1:0] quanta_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_t;

  function automatic quanta_t len_from_code(input logic [SEG_W-1:0] code);
    return quanta_t'(code) + quanta_t'(1);
  endfunction

  function automatic quanta_t ph2_from_code(input logic [SEG_W-1:0] code);
    return (code == '0) ? quanta_t'(2) : quanta_t'(code) + quanta_t'(1);
  endfunction

  function automatic quanta_t sjw_from_code(input logic [SJW_W-1:0] code);
    return quanta_t'(code) + quanta_t'(1);
  endfunction

  function automatic quanta_t cap(input quanta_t a, input quanta_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/cbt_tq_divider.sv
module cbt_tq_divider #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] div_code,
  input  logic             restart,
  output logic             tq_tick
);
  logic [BRP_W-1:0] cnt_q;

  assign tq_tick = (cnt_q >= div_code);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart)       cnt_q <= '0;
    else if (tq_tick)       cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  AST_TQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && div_code != '0 && !restart) |=> !tq_tick); // R2
endmodule

// File: rtl/cbt_edge_detect.sv
module cbt_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  output logic edge_fall
);
  logic rx_prev_q;

  assign edge_fall = rx_prev_q & ~rx_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_prev_q <= 1'b1;
    else        rx_prev_q <= rx_bit;
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |=> !edge_fall); // R6
endmodule

// File: rtl/cbt_segment_fsm.sv
module cbt_segment_fsm
  import cbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             edge_fall,
  input  logic             bus_idle,
  input  logic             tx_bit,
  input  logic [SEG_W-1:0] prop_code,
  input  logic [SEG_W-1:0] ph1_code,
  input  logic [SEG_W-1:0] ph2_code,
  input  logic [SJW_W-1:0] sjw_code,
  output logic             hard_sync,
  output logic             resync_evt,
  output logic             sample_evt,
  output logic             tx_evt
);
  seg_t    seg_q;
  quanta_t qcnt_q, ext_q, shr_q;
  logic    synced_q;

  quanta_t prop_q, ph1_q, ph2_q, sjw_q;
  quanta_t late_e, early_rem, ext_eff, shr_eff, seg_len;
  logic    late, early, last_q, tx_nat;
  seg_t    seg_next;

  assign prop_q = len_from_code(prop_code);
  assign ph1_q  = len_from_code(ph1_code);
  assign ph2_q  = ph2_from_code(ph2_code);
  assign sjw_q  = sjw_from_code(sjw_code);

  assign hard_sync  = edge_fall && bus_idle && !synced_q;
  assign resync_evt = edge_fall && !bus_idle && tx_bit && !synced_q && (seg_q != SEG_SYNC);
  assign late       = resync_evt && (seg_q == SEG_PROP || seg_q == SEG_PH1);
  assign early      = resync_evt && (seg_q == SEG_PH2);

  assign late_e    = (seg_q == SEG_PROP) ? qcnt_q + quanta_t'(1)
                                         : prop_q + qcnt_q + quanta_t'(1);
  assign early_rem = ph2_q - quanta_t'(1) - qcnt_q;
  assign ext_eff   = late  ? cap(late_e, sjw_q)    : ext_q;
  assign shr_eff   = early ? cap(early_rem, sjw_q) : shr_q;

  always_comb begin
    case (seg_q)
      SEG_SYNC: begin seg_len = quanta_t'(1);      seg_next = SEG_PROP; end
      SEG_PROP: begin seg_len = prop_q;            seg_next = SEG_PH1;  end
      SEG_PH1:  begin seg_len = ph1_q + ext_eff;   seg_next = SEG_PH2;  end
      default:  begin seg_len = ph2_q - shr_eff;   seg_next = SEG_SYNC; end
    endcase
  end

  assign last_q     = (qcnt_q == seg_len - quanta_t'(1));
  assign sample_evt = !hard_sync && tq_tick && last_q && (seg_q == SEG_PH1);
  assign tx_nat     = !hard_sync && tq_tick && last_q && (seg_q == SEG_PH2);
  assign tx_evt     = tx_nat || hard_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q    <= SEG_SYNC;
      qcnt_q   <= '0;
      ext_q    <= '0;
      shr_q    <= '0;
      synced_q <= 1'b0;
    end else if (hard_sync) begin
      seg_q    <= SEG_SYNC;
      qcnt_q   <= '0;
      ext_q    <= '0;
      shr_q    <= '0;
      synced_q <= 1'b1;
    end else begin
      if (tq_tick) begin
        if (last_q) begin
          seg_q  <= seg_next;
          qcnt_q <= '0;
        end else begin
          qcnt_q <= qcnt_q + quanta_t'(1);
        end
      end
      ext_q    <= tx_nat ? '0 : ext_eff;
      shr_q    <= tx_nat ? '0 : shr_eff;
      synced_q <= tx_nat ? 1'b0 : (synced_q | resync_evt);
    end
  end

  AST_EXT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q <= sjw_q); // R7
  AST_SHR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    shr_q <= sjw_q); // R8
  AST_SAMPLE_TO_PH2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> seg_q == SEG_PH2); // R4
  AST_TX_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> (seg_q == SEG_SYNC && qcnt_q == '0)); // R3
  AST_OWN_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_fall && !tx_bit) |-> !resync_evt); // R9
  AST_ONE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (synced_q && !tx_evt) |=> (ext_q == $past(ext_q) && shr_q == $past(shr_q))); // R10
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import cbt_pkg::*;
#(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] tq_div,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw_len,
  input  logic             rx_bit,
  input  logic             tx_bit,
  input  logic             bus_idle,
  output logic             sample_bit,
  output logic             sample_stb,
  output logic             tx_stb,
  output logic             bit_err
);
  logic tq_tick, edge_fall, hard_sync, resync_evt, sample_evt, tx_evt;

  cbt_tq_divider #(.BRP_W(BRP_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_code(tq_div),
    .restart(hard_sync), .tq_tick(tq_tick)
  );

  cbt_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .edge_fall(edge_fall)
  );

  cbt_segment_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .edge_fall(edge_fall),
    .bus_idle(bus_idle), .tx_bit(tx_bit),
    .prop_code(prop_len), .ph1_code(ph1_len), .ph2_code(ph2_len), .sjw_code(sjw_len),
    .hard_sync(hard_sync), .resync_evt(resync_evt),
    .sample_evt(sample_evt), .tx_evt(tx_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_bit <= 1'b1;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      bit_err    <= 1'b0;
    end else begin
      sample_stb <= sample_evt;
      tx_stb     <= tx_evt;
      if (sample_evt) begin
        sample_bit <= rx_bit;
        bit_err    <= (rx_bit != tx_bit);
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb)); // R3
  AST_ERR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (bit_err == (sample_bit != $past(tx_bit)))); // R11
  AST_RESYNC_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resync_evt |-> !bus_idle); // R7
endmodule

// File: tb/sim_can_bit_timing.sv
`timescale 1ns/1ps
module sim_can_bit_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] tq_div = '0;
  logic [2:0] prop_len = '0, ph1_len = '0, ph2_len = '0;
  logic [1:0] sjw_len = '0;
  logic       rx_bit = 1'b1, tx_bit = 1'b1, bus_idle = 1'b0;
  logic       sample_bit, sample_stb, tx_stb, bit_err;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  can_bit_timing u0 (
    .clk(clk), .rst_n(rst_n), .tq_div(tq_div), .prop_len(prop_len),
    .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw_len(sjw_len),
    .rx_bit(rx_bit), .tx_bit(tx_bit), .bus_idle(bus_idle),
    .sample_bit(sample_bit), .sample_stb(sample_stb), .tx_stb(tx_stb), .bit_err(bit_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input int b, input int p, input int p1, input int p2, input int s);
    @(negedge clk);
    rst_n = 1'b0;
    tq_div = 6'(b); prop_len = 3'(p); ph1_len = 3'(p1); ph2_len = 3'(p2); sjw_len = 2'(s);
    rx_bit = 1'b1; tx_bit = 1'b1; bus_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_tx();
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (tx_stb) return;
    end
    check(1'b0, "R3 tx_stb timeout", 0, 1);
  endtask

  task automatic wait_sample();
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (sample_stb) return;
    end
    check(1'b0, "R4 sample_stb timeout", 0, 1);
  endtask

  // From a tx_stb cycle (c=0) count cycles to sample_stb and the next tx_stb,
  // driving rx_bit to dv[k] at cycle dc[k].
  task automatic run_bit(input int dc[3], input logic dv[3], output int cs, output int ct);
    int c = 0;
    cs = -1; ct = -1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      c++;
      if (sample_stb && cs < 0) cs = c;
      if (tx_stb) begin ct = c; return; end
      for (int k = 0; k < 3; k++) if (dc[k] == c) rx_bit = dv[k];
    end
  endtask

  function automatic int ph2q(input int code);
    return (code == 0) ? 2 : code + 1;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(sample_bit == 1'b1 && !sample_stb && !tx_stb && !bit_err, "R1 in reset",
          {sample_bit, sample_stb, tx_stb, bit_err}, 4'b1000);
    apply_reset(3, 2, 3, 4, 1);
    @(negedge clk);
    check(sample_bit == 1'b1, "R1 sample_bit after release", sample_bit, 1);
    check(!sample_stb && !tx_stb, "R1 strobes after release", {sample_stb, tx_stb}, 0);
    check(!bit_err, "R1 bit_err after release", bit_err, 0);
  endtask

  task automatic t_timing(input int b, input int p, input int p1, input int p2, input string tag);
    int cs, ct, n, es, et;
    apply_reset(b, p, p1, p2, 1);
    wait_tx();
    run_bit('{-1, -1, -1}, '{1'b1, 1'b1, 1'b1}, cs, ct);
    n  = b + 1;
    es = n * (1 + (p + 1) + (p1 + 1));
    et = n * (1 + (p + 1) + (p1 + 1) + ph2q(p2));
    check(cs == es, {tag, " R4 sample point"}, cs, es);
    check(ct == et, {tag, " R3 bit period"}, ct, et);
  endtask

  // Config: N=4, P=3, P1=3, P2=4, jump width 2 -> sample 28, bit 44
  task automatic t_resync_late(input int q, input int ext);
    int cs, ct;
    apply_reset(3, 2, 2, 3, 1);
    wait_tx();
    run_bit('{4 * (1 + q), -1, -1}, '{1'b0, 1'b1, 1'b1}, cs, ct);
    check(cs == 4 * (7 + ext), "R7 stretched sample point", cs, 4 * (7 + ext));
    check(ct == 4 * (11 + ext), "R7 stretched bit", ct, 4 * (11 + ext));
  endtask

  task automatic t_resync_early(input int j, input int shr);
    int cs, ct;
    apply_reset(3, 2, 2, 3, 1);
    wait_tx();
    run_bit('{4 * (7 + j), -1, -1}, '{1'b0, 1'b1, 1'b1}, cs, ct);
    check(cs == 28, "R8 sample point unchanged", cs, 28);
    check(ct == 4 * (11 - shr), "R8 shortened bit", ct, 4 * (11 - shr));
  endtask

  task automatic t_own_tx();
    int cs, ct;
    apply_reset(3, 2, 2, 3, 1);
    tx_bit = 1'b0;
    wait_tx();
    run_bit('{4, -1, -1}, '{1'b0, 1'b1, 1'b1}, cs, ct);
    check(cs == 28, "R9 own dominant edge sample", cs, 28);
    check(ct == 44, "R9 own dominant edge bit", ct, 44);
  endtask

  task automatic t_one_sync();
    int cs, ct;
    apply_reset(3, 2, 2, 3, 1);
    wait_tx();
    run_bit('{4, 6, 20}, '{1'b0, 1'b1, 1'b0}, cs, ct);
    check(cs == 32, "R10 second edge ignored sample", cs, 32);
    check(ct == 48, "R10 second edge ignored bit", ct, 48);
  endtask

  task automatic t_hard_sync();
    int cs, ct;
    apply_reset(2, 0, 0, 0, 0);
    bus_idle = 1'b1;
    repeat (5) @(negedge clk);
    check(!tx_stb, "R6 no strobe before edge", tx_stb, 0);
    rx_bit = 1'b0;
    @(negedge clk);
    check(tx_stb == 1'b1, "R6 strobe after idle edge", tx_stb, 1);
    run_bit('{-1, -1, -1}, '{1'b1, 1'b1, 1'b1}, cs, ct);
    check(cs == 9, "R6 sample after hard sync", cs, 9);
    check(ct == 15, "R6 bit after hard sync", ct, 15);
  endtask

  task automatic t_bit_err();
    apply_reset(3, 2, 2, 3, 1);
    tx_bit = 1'b0;
    rx_bit = 1'b0;
    wait_sample();
    check(sample_bit == 1'b0, "R11 dominant sampled", sample_bit, 0);
    check(bit_err == 1'b0, "R11 match no error", bit_err, 0);
    tx_bit = 1'b1;
    wait_sample();
    check(sample_bit == 1'b0, "R11 dominant overrides recessive tx", sample_bit, 0);
    check(bit_err == 1'b1, "R11 recessive tx dominant bus", bit_err, 1);
    wait_tx();
    check(bit_err == 1'b1, "R11 error held between samples", bit_err, 1);
    tx_bit = 1'b0;
    rx_bit = 1'b1;
    wait_sample();
    check(sample_bit == 1'b1 && bit_err == 1'b1, "R11 dominant tx recessive bus",
          {sample_bit, bit_err}, 3);
    tx_bit = 1'b1;
    wait_sample();
    check(bit_err == 1'b0, "R11 recessive match", bit_err, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_timing(3, 2, 3, 4, "R3");
    t_timing(0, 7, 7, 7, "R2 div1");
    t_timing(63, 0, 0, 1, "R2 div64");
    t_timing(2, 1, 1, 0, "R5 ph2 code0");
    t_resync_late(0, 1);
    t_resync_late(2, 2);
    t_resync_early(0, 2);
    t_resync_early(2, 1);
    t_own_tx();
    t_one_sync();
    t_hard_sync();
    t_bit_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule